// File: doc/BRIEF.md
# Slave Configuration Table with Break Reset

This block is a small, read-mostly discovery window placed at the bottom of a slave's register space. Software walks it word by word to learn what the slave contains: first a chip identifier, then two fixed engine-description words, then one configuration word for each device attached to the slave's local bus. A zero word closes the list, and every word past that point returns a fixed filler pattern so that a runaway scan is easy to spot.

The window is reached over a plain 32-bit bus with a byte address, read and write strobes, an access size and write data. Only full-word, word-aligned accesses are legal. Bits 31:24 of each word form the most significant byte, which goes first on the big-endian bus. The table itself cannot be written. The one exception is a magic key written to the identifier word, which sends a single-cycle reset pulse to everything on the local bus. Device words come from an input vector whose width follows a device-count parameter.

Top module: `cfg_table`

## Requirements
- R1: After reset, rdata_o is 0, rvalid_o is 0, err_o is 0 and bus_rst_o is 0.
- R2: A read strobed at a clock edge makes rvalid_o high for exactly the next cycle, with rdata_o holding the word. rvalid_o is low in every cycle that does not follow a read.
- R3: A read of byte offset 0x000 returns the CHIP_ID parameter (default 0xC0022D15).
- R4: Offset 0x004 returns 0x8001102C and offset 0x008 returns 0x8001503A. The layout is: bit 31 is the continuation flag, bits 19:16 the slot count (1), bits 15:12 the version (1, then 5), bits 11:4 the engine type (0x02 peek, then 0x03 link), and bits 3:0 a check value (0xC, then 0xA).
- R5: Offset 0x00C + 4*k, for k below NUM_DEV, returns bits 32k+31:32k of dev_cfg_i.
- R6: Offset 0x00C + 4*NUM_DEV returns 0x00000000.
- R7: Every aligned offset after the terminator, up to 0x3FC, returns 0xC0DE0000.
- R8: A valid write of 0xC0DE0000 to offset 0x000 makes bus_rst_o high for exactly the cycle that follows the write.
- R9: A write of any other value to offset 0x000, or of any value to any other offset, creates no pulse and leaves all read data unchanged.
- R10: An access with size_i not equal to 4, or with addr_i[1:0] not zero, sets err_o. Such a read returns 0, and such a write creates no pulse.
- R11: Once err_o is set, it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address within the window |
| size_i | input | 3 | Access size in bytes (only 4 is legal) |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| dev_cfg_i | input | 32*NUM_DEV | Configuration words of the attached devices, device 0 in the lowest bits |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after the read strobe |
| err_o | output | 1 | Sticky flag for a misaligned or wrong-size access |
| bus_rst_o | output | 1 | Single-cycle local-bus reset pulse |

## Verification
Every cycle, the assertions check the following: the read-valid timing, that the error flag stays set, that an illegal read returns zero, and that every reset pulse comes from a legal key write to the identifier word and never from an illegal access. The actual table contents can only be shown by the bench's scenarios. These are the chip identifier, the packed engine words, the per-device slices, the placement of the terminator and the filler at the far end of the window. The bench scenarios also cover the near-miss writes that must be ignored.

// File: rtl/cfg_table_pkg.sv
package cfg_table_pkg;
  localparam int          WORD_W      = 32;
  localparam int          FIXED_WORDS = 3;
  localparam logic [31:0] FILLER      = 32'hC0DE_0000;
  localparam logic [31:0] BREAK_KEY   = 32'hC0DE_0000;

  // continuation flag | slot count | version | type | check
  function automatic logic [31:0] eng_word(logic [7:0] ty, logic [3:0] ver, logic [3:0] chk);
    return 32'h8000_0000 | 32'h0001_0000 | {16'd0, ver, 12'd0} | {20'd0, ty, 4'd0} | {28'd0, chk};
  endfunction
endpackage

// File: rtl/cfg_table_rom.sv
module cfg_table_rom
  import cfg_table_pkg::*;
#(
  parameter int          NUM_DEV   = 4,
  parameter int          IDX_W     = 8,
  parameter logic [31:0] CHIP_ID   = 32'hC002_2D15,
  parameter logic [7:0]  PEEK_TYPE = 8'h02,
  parameter logic [7:0]  LINK_TYPE = 8'h03
) (
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [NUM_DEV*WORD_W-1:0] dev_cfg_i,
  output logic [WORD_W-1:0]         word_o
);
  localparam int TERM_IDX = FIXED_WORDS + NUM_DEV;

  logic [WORD_W-1:0] dev_word;

  always_comb begin
    dev_word = '0;
    for (int k = 0; k < NUM_DEV; k++) begin
      if (int'(idx_i) == FIXED_WORDS + k) dev_word = dev_cfg_i[k*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    if (int'(idx_i) == 0)             word_o = CHIP_ID;
    else if (int'(idx_i) == 1)        word_o = eng_word(PEEK_TYPE, 4'h1, 4'hC);
    else if (int'(idx_i) == 2)        word_o = eng_word(LINK_TYPE, 4'h5, 4'hA);
    else if (int'(idx_i) < TERM_IDX)  word_o = dev_word;
    else if (int'(idx_i) == TERM_IDX) word_o = '0;
    else                              word_o = FILLER;
  end
endmodule

// File: rtl/cfg_table_break.sv
module cfg_table_break
  import cfg_table_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ok_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= wr_ok_i && (idx_i == '0) && (wdata_i == BREAK_KEY);
  end
endmodule

// File: rtl/cfg_table.sv
module cfg_table
  import cfg_table_pkg::*;
#(
  parameter int          ADDR_W    = 10,
  parameter int          NUM_DEV   = 4,
  parameter logic [31:0] CHIP_ID   = 32'hC002_2D15,
  parameter logic [7:0]  PEEK_TYPE = 8'h02,
  parameter logic [7:0]  LINK_TYPE = 8'h03
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [2:0]                size_i,
  input  logic                      rd_i,
  input  logic                      wr_i,
  input  logic [31:0]               wdata_i,
  input  logic [32*NUM_DEV-1:0]     dev_cfg_i,
  output logic [31:0]               rdata_o,
  output logic                      rvalid_o,
  output logic                      err_o,
  output logic                      bus_rst_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              bad;
  logic [WORD_W-1:0] rom_word;

  assign idx = addr_i[ADDR_W-1:2];
  assign bad = (size_i != 3'd4) || (addr_i[1:0] != 2'b00);

  cfg_table_rom #(
    .NUM_DEV(NUM_DEV), .IDX_W(IDX_W), .CHIP_ID(CHIP_ID),
    .PEEK_TYPE(PEEK_TYPE), .LINK_TYPE(LINK_TYPE)
  ) u_rom (
    .idx_i(idx), .dev_cfg_i(dev_cfg_i), .word_o(rom_word)
  );

  cfg_table_break #(.IDX_W(IDX_W)) u_break (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_ok_i(wr_i && !bad),
    .idx_i(idx), .wdata_i(wdata_i), .pulse_o(bus_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= bad ? '0 : rom_word;
      if ((rd_i || wr_i) && bad) err_o <= 1'b1;
    end
  end

  p_rvalid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
  p_rvalid_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);
  p_bad_read_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (size_i != 3'd4 || addr_i[1:0] != 2'b00)) |=> (rdata_o == '0 && err_o));
  p_bad_write_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (size_i != 3'd4 || addr_i[1:0] != 2'b00)) |=> !bus_rst_o);
  p_pulse_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_rst_o) |-> $past(wr_i && addr_i == '0 && size_i == 3'd4 && wdata_i == BREAK_KEY));
  p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

// File: tb/tb_cfg_table.sv
`timescale 1ns/1ps
module tb_cfg_table;
  localparam int NUM_DEV = 4;
  localparam int NVEC    = 12;
  // {byte address, expected word}
  localparam logic [41:0] VEC [NVEC] = '{
    {10'h000, 32'hC002_2D15},  // R3
    {10'h004, 32'h8001_102C},  // R4
    {10'h008, 32'h8001_503A},  // R4
    {10'h00C, 32'h1000_0001},  // R5
    {10'h010, 32'h1101_0101},  // R5
    {10'h014, 32'h1202_0201},  // R5
    {10'h018, 32'h1303_0301},  // R5
    {10'h01C, 32'h0000_0000},  // R6
    {10'h020, 32'hC0DE_0000},  // R7
    {10'h100, 32'hC0DE_0000},  // R7
    {10'h3FC, 32'hC0DE_0000},  // R7
    {10'h000, 32'hC002_2D15}   // R3 again
  };

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [9:0]            addr = '0;
  logic [2:0]            size = 3'd4;
  logic                  rd = 1'b0, wr = 1'b0;
  logic [31:0]           wdata = '0;
  logic [32*NUM_DEV-1:0] dev_cfg;
  logic [31:0]           rdata;
  logic                  rvalid, err, bus_rst;
  int                    n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  always_comb
    for (int k = 0; k < NUM_DEV; k++)
      dev_cfg[k*32 +: 32] = 32'h1000_0001 + k * 32'h0101_0100;

  cfg_table #(.NUM_DEV(NUM_DEV)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .size_i(size), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .dev_cfg_i(dev_cfg), .rdata_o(rdata), .rvalid_o(rvalid),
    .err_o(err), .bus_rst_o(bus_rst)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Returns with rvalid cycle current.
  task automatic do_read(logic [9:0] a, logic [2:0] s);
    @(negedge clk); addr = a; size = s; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  // Returns in the cycle right after the write.
  task automatic do_write(logic [9:0] a, logic [2:0] s, logic [31:0] d);
    @(negedge clk); addr = a; size = s; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdata", rdata, 0);
    check("R1 rvalid", {31'd0, rvalid}, 0);
    check("R1 err", {31'd0, err}, 0);
    check("R1 bus_rst", {31'd0, bus_rst}, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      do_read(VEC[i][41:32], 3'd4);
      check("R2 rvalid", {31'd0, rvalid}, 1);
      check("R3-7 table word", rdata, VEC[i][31:0]);
    end
    @(negedge clk);
    check("R2 rvalid drops", {31'd0, rvalid}, 0);

    // R8 break pulse
    do_write(10'h000, 3'd4, 32'hC0DE_0000);
    check("R8 pulse high", {31'd0, bus_rst}, 1);
    @(negedge clk);
    check("R8 pulse one cycle", {31'd0, bus_rst}, 0);

    // R9 ignored writes
    do_write(10'h004, 3'd4, 32'hC0DE_0000);
    check("R9 key at other offset", {31'd0, bus_rst}, 0);
    do_write(10'h000, 3'd4, 32'hC0DE_0001);
    check("R9 wrong value", {31'd0, bus_rst}, 0);
    do_write(10'h00C, 3'd4, 32'hFFFF_FFFF);
    check("R9 write device slot", {31'd0, bus_rst}, 0);
    do_read(10'h00C, 3'd4);
    check("R9 device word kept", rdata, 32'h1000_0001);
    do_read(10'h000, 3'd4);
    check("R9 chip id kept", rdata, 32'hC002_2D15);
    check("R9 no error", {31'd0, err}, 0);

    // R10 illegal accesses
    do_write(10'h001, 3'd4, 32'hC0DE_0000);
    check("R10 misaligned key write no pulse", {31'd0, bus_rst}, 0);
    check("R10 err set by write", {31'd0, err}, 1);
    do_read(10'h002, 3'd4);
    check("R10 misaligned read zero", rdata, 0);
    do_read(10'h000, 3'd2);
    check("R10 short read zero", rdata, 0);
    do_write(10'h000, 3'd2, 32'hC0DE_0000);
    check("R10 short key write no pulse", {31'd0, bus_rst}, 0);

    // R11 sticky
    do_read(10'h004, 3'd4);
    check("R11 err held", {31'd0, err}, 1);
    check("R11 good read after error", rdata, 32'h8001_102C);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    check("R11 err cleared by reset", {31'd0, err}, 0);
    rst_ni = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule